// File: doc/BRIEF.md
# S-record text stream parser

This block reads a stream of ASCII characters, one per cycle in which a valid strobe is high, and interprets it as Motorola S-record text. Every data byte of a 32-bit-address data record becomes a single write transaction: a 32-bit address and an 8-bit value, presented for exactly one cycle. Memory is therefore filled byte by byte at the addresses that the text gives. Nothing is buffered. A byte is written as soon as its second hex digit arrives, which is before the record's checksum is known.

A loading flag rises when a record begins and falls only when a termination record arrives with a correct checksum. It is meant to hold a processor in reset while its program is being loaded. A checksum mismatch, a malformed record or a stray character inside a record sets a sticky error flag. Once that flag is set, the loading flag can no longer be released until reset, so a corrupted image is never run.

Top module: `srec_loader`

## Requirements
- R1: After reset, `loading`, `wr_valid` and `cksum_err` are all 0.
- R2: When an 'S' (8'h53) is accepted outside a record, `loading` is 1 from the next cycle on.
- R3: In a type '3' record, each data byte produces one `wr_valid` pulse in the cycle after its second hex digit is accepted. The pulse carries that byte on `wr_data`. Its `wr_addr` is the record's start address plus the byte's index, starting at 0, with the carry reaching into the upper address bytes. Writes happen even if the checksum later fails.
- R4: The two characters after 'S' and the type digit are the byte count. The count covers the address, data and checksum bytes. Types '3' and '7' carry 4 address bytes, most significant byte first. Type '0' carries 2 address bytes.
- R5: A type '0' record produces no writes. A correct checksum on it leaves `cksum_err` at 0.
- R6: A type '7' record with a correct checksum, and no earlier error, drives `loading` to 0 in the cycle after its last checksum digit. It produces no writes.
- R7: A record's checksum byte must equal the one's complement of the 8-bit sum of its count, address and data bytes. A mismatch sets `cksum_err`, which stays 1 until reset. While `cksum_err` is 1, `loading` is never released, even by a correct type '7' record.
- R8: Outside a record, carriage return, line feed and every other character except 'S' are ignored. They leave `loading`, `cksum_err` and `wr_valid` unchanged.
- R9: Hex digits 0-9, A-F and a-f are all accepted. A non-hex character inside the count, address, data or checksum field sets `cksum_err` and abandons the record.
- R10: A record whose type digit is not '0', '3' or '7' is skipped up to the next 'S'. It produces no writes and does not set `cksum_err`.
- R11: A byte count of zero sets `cksum_err` and abandons the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | 1 | Character strobe |
| ch_data | input | 8 | ASCII character |
| wr_valid | output | 1 | One-cycle write pulse |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte value of the write |
| loading | output | 1 | Load in progress; holds the processor in reset |
| cksum_err | output | 1 | Sticky format or checksum error |

## Verification
Two functions meet on the final checksum digit of a termination record: the release of `loading` and the checksum verdict. Both are decided on the same edge. The bench provokes this meeting with a correct termination record after clean data, which must drop `loading` with the error flag still 0. It then provokes it with a correct termination record after a data record whose checksum was corrupted, which must leave `loading` at 1 with the error flag held. A second overlap is a data write on the same edge as the running-sum update. The bench judges it through the final checksum verdict of records that also carry writes.

// File: rtl/srec_pkg.sv
package srec_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_TYPE, PS_BYTES, PS_SKIP} prs_state_t;
  typedef enum logic [1:0] {RK_HDR, RK_DATA, RK_TERM} rec_kind_t;

  localparam logic [7:0] CH_S = 8'h53;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  // Letters of both cases have 1..6 in the low nibble; add 9 to reach 10..15.
  function automatic logic [3:0] hex_nib(input logic [7:0] c);
    return (c <= 8'h39) ? c[3:0] : c[3:0] + 4'd9;
  endfunction

  // Number of address bytes for a type digit; 0 marks an unsupported type.
  function automatic logic [2:0] addr_bytes(input logic [7:0] c);
    case (c)
      8'h30:        return 3'd2;
      8'h33, 8'h37: return 3'd4;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic logic sum_ok(input logic [7:0] acc, input logic [7:0] ck);
    logic [7:0] t;
    t = acc + ck;
    return t == 8'hFF;
  endfunction
endpackage

// File: rtl/srec_nibble_pair.sv
module srec_nibble_pair
  import srec_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              ch_valid,
  input  logic [CHAR_W-1:0] ch_data,
  output logic              byte_stb,
  output logic [7:0]        byte_val
);
  logic       have_hi;
  logic [3:0] hi_q;
  logic       take;

  assign take     = en && ch_valid && is_hex(ch_data[7:0]);
  assign byte_stb = take && have_hi;
  assign byte_val = {hi_q, hex_nib(ch_data[7:0])};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      have_hi <= 1'b0;
      hi_q    <= '0;
    end else if (take) begin
      have_hi <= !have_hi;
      if (!have_hi) hi_q <= hex_nib(ch_data[7:0]);
    end
  end
endmodule

// File: rtl/srec_sum.sv
module srec_sum #(
  parameter int SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [SUM_W-1:0] val,
  output logic [SUM_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (add)      acc <= acc + val;
  end
endmodule

// File: rtl/srec_loader.sv
module srec_loader
  import srec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              loading,
  output logic              cksum_err
);
  localparam int ABW = $clog2(ADDR_W / 8 + 1);

  prs_state_t        state;
  rec_kind_t         kind;
  logic [ABW-1:0]    alen, abytes;
  logic [CNT_W-1:0]  remain;
  logic              have_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        acc;

  // Named events, also used by the checker.
  logic       rec_start, in_bytes, bad_char, byte_stb, last_byte;
  logic       ck_good, term_release;
  logic [7:0] byte_val;

  assign rec_start    = ch_valid && ch_data == CH_S &&
                        (state == PS_IDLE || state == PS_SKIP);
  assign in_bytes     = state == PS_BYTES;
  assign bad_char     = in_bytes && ch_valid && !is_hex(ch_data);
  assign last_byte    = byte_stb && have_cnt && remain == CNT_W'(1);
  assign ck_good      = sum_ok(acc, byte_val);
  assign term_release = last_byte && ck_good && kind == RK_TERM && !cksum_err;

  srec_nibble_pair #(.CHAR_W(8)) u_pair (
    .clk(clk), .rst_n(rst_n), .clr(rec_start), .en(in_bytes),
    .ch_valid(ch_valid), .ch_data(ch_data),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  srec_sum #(.SUM_W(8)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr(rec_start), .add(byte_stb),
    .val(byte_val), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      kind      <= RK_HDR;
      alen      <= '0;
      abytes    <= '0;
      remain    <= '0;
      have_cnt  <= 1'b0;
      addr_q    <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      loading   <= 1'b0;
      cksum_err <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      case (state)
        PS_IDLE, PS_SKIP: begin
          if (rec_start) begin
            state   <= PS_TYPE;
            loading <= 1'b1;
          end
        end
        PS_TYPE: begin
          if (ch_valid) begin
            if (addr_bytes(ch_data) != 3'd0) begin
              state    <= PS_BYTES;
              alen     <= ABW'(addr_bytes(ch_data));
              kind     <= (ch_data == 8'h30) ? RK_HDR :
                          (ch_data == 8'h33) ? RK_DATA : RK_TERM;
              have_cnt <= 1'b0;
              abytes   <= '0;
              addr_q   <= '0;
            end else begin
              state <= PS_SKIP;
            end
          end
        end
        PS_BYTES: begin
          if (bad_char) begin
            cksum_err <= 1'b1;
            state     <= PS_IDLE;
          end else if (byte_stb) begin
            if (!have_cnt) begin
              if (byte_val == 8'd0) begin
                cksum_err <= 1'b1;
                state     <= PS_IDLE;
              end else begin
                remain   <= CNT_W'(byte_val);
                have_cnt <= 1'b1;
              end
            end else begin
              remain <= remain - CNT_W'(1);
              if (last_byte) begin
                state <= PS_IDLE;
                if (!ck_good)     cksum_err <= 1'b1;
                if (term_release) loading   <= 1'b0;
              end else if (abytes < alen) begin
                addr_q <= {addr_q[ADDR_W-9:0], byte_val};
                abytes <= abytes + ABW'(1);
              end else if (kind == RK_DATA) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= byte_val;
                addr_q   <= addr_q + ADDR_W'(1);
              end
            end
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srec_loader_chk.sv
module srec_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ch_valid,
  input logic [7:0] ch_data,
  input logic       wr_valid,
  input logic       loading,
  input logic       cksum_err,
  input logic       rec_start,
  input logic       term_release
);
  a_r2_start_sets_loading: assert property (@(posedge clk) disable iff (!rst_n)
    rec_start |=> loading);
  a_r2_rise_only_on_s: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loading) |-> $past(ch_valid && ch_data == 8'h53));
  a_r3_write_follows_char: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(ch_valid));
  a_r3_write_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> loading);
  a_r6_release_on_term: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> $past(term_release));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cksum_err |=> cksum_err);
  a_r7_no_release_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> !cksum_err);
endmodule

bind srec_loader srec_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
  .wr_valid(wr_valid), .loading(loading), .cksum_err(cksum_err),
  .rec_start(rec_start), .term_release(term_release)
);

// File: tb/sim_srec_loader.sv
module sim_srec_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_valid = 1'b0;
  logic [7:0]  ch_data = 8'h00;
  logic        wr_valid, loading, cksum_err;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [39:0] exp_q[$];
  logic [7:0]  none[$];

  always #5 clk = !clk;

  srec_loader u0 (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .loading(loading), .cksum_err(cksum_err)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every write pulse is popped and compared (R3).
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) chk("R3 unexpected write", {wr_addr, wr_data}, 40'h0);
      else chk("R3 write addr/data", {wr_addr, wr_data}, exp_q.pop_front());
    end
  end

  function automatic logic [7:0] hx(input logic [3:0] n, input bit lc);
    if (n < 4'd10) return 8'h30 + 8'(n);
    return (lc ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
  endfunction

  task automatic send_char(input logic [7:0] c);
    ch_valid = 1'b1;
    ch_data  = c;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic send_hex(input logic [7:0] b, input bit lc);
    send_char(hx(b[7:4], lc));
    send_char(hx(b[3:0], lc));
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Builds a record; pushes expected writes when exp_wr is set.
  task automatic send_rec(input logic [7:0] t, input logic [31:0] a, input int alen,
                          input logic [7:0] d[$], input bit lc, input bit bad,
                          input bit exp_wr, input bit chk_start);
    logic [7:0] cnt, sum, ab;
    cnt = 8'(alen + d.size() + 1);
    sum = cnt;
    send_char(8'h53);
    if (chk_start) chk("R2 loading after S", 40'(loading), 40'd1);
    send_char(t);
    send_hex(cnt, lc);
    for (int i = 0; i < alen; i++) begin
      ab = 8'(a >> (8 * (alen - 1 - i)));
      sum = sum + ab;
      send_hex(ab, lc);
    end
    for (int i = 0; i < d.size(); i++) begin
      if (exp_wr) exp_q.push_back({a + 32'(i), d[i]});
      sum = sum + d[i];
      send_hex(d[i], lc);
    end
    send_hex((~sum) ^ {7'd0, bad}, lc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 loading reset", 40'(loading), 40'd0);
    chk("R1 wr_valid reset", 40'(wr_valid), 40'd0);
    chk("R1 cksum_err reset", 40'(cksum_err), 40'd0);

    send_str("\r\nx7");
    chk("R8 idle chars keep loading", 40'(loading), 40'd0);
    chk("R8 idle chars keep err", 40'(cksum_err), 40'd0);

    send_rec(8'h30, 32'h0000, 2, '{8'h48, 8'h44, 8'h52}, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 header no error", 40'(cksum_err), 40'd0);
    send_str("\r\n");
    chk("R8 line end keeps loading", 40'(loading), 40'd1);

    send_rec(8'h33, 32'h0000_1000, 4, '{8'h11, 8'h22, 8'hA5, 8'h3C}, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 data record ok", 40'(cksum_err), 40'd0);
    send_str("\r\n");
    send_rec(8'h33, 32'h1234_ABFE, 4, '{8'hde, 8'had, 8'hbe, 8'hef, 8'h5a}, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 lowercase hex ok", 40'(cksum_err), 40'd0);

    send_str("S5030001FB\r\n");
    chk("R10 unsupported type no error", 40'(cksum_err), 40'd0);
    chk("R10 unsupported type keeps loading", 40'(loading), 40'd1);

    send_rec(8'h37, 32'h0000_1000, 4, none, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 termination releases loading", 40'(loading), 40'd0);
    chk("R6 termination no error", 40'(cksum_err), 40'd0);
    chk("R3 all writes seen", 40'(exp_q.size()), 40'd0);

    do_reset();
    send_rec(8'h33, 32'h0000_2000, 4, '{8'hAA, 8'hBB}, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 bad checksum sets err", 40'(cksum_err), 40'd1);
    chk("R7 bad checksum keeps loading", 40'(loading), 40'd1);
    send_rec(8'h37, 32'h0000_2000, 4, none, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 termination after error keeps loading", 40'(loading), 40'd1);
    chk("R7 error stays set", 40'(cksum_err), 40'd1);

    do_reset();
    send_str("S305G0");
    chk("R9 non-hex in record sets err", 40'(cksum_err), 40'd1);

    do_reset();
    send_str("S300");
    chk("R11 zero count sets err", 40'(cksum_err), 40'd1);

    repeat (3) @(negedge clk);
    chk("R3 no pending writes", 40'(exp_q.size()), 40'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule